// File: doc/BRIEF.md
# Masked interrupt flag and mask register unit

This unit collects one-cycle event pulses from a microcontroller's peripherals (timers, external pin logic, the ADC, the SPI and UART engines, and a time-base timer) into two 8-bit flag registers. Each flag register has its own 8-bit mask register. Firmware reads the flags through a small register port. A read returns only the flag bits that are currently enabled by the mask. Firmware acknowledges an event by writing 0 to its flag bit. Writing 1 leaves the bit as it is, so firmware can never create a flag.

A separate single-bit flag for the first external pin sits beside the two registers. That flag is held at 0 while its enable level is low, which makes the enable act as its mask. The receive-error flag of the UART is held clear while the UART enable level is low.

The unit drives one interrupt request line. The line is the OR of every unmasked flag, registered once. There is no state machine: every bit is an independent sticky flop. The register port is combinational on the read side and takes effect at the clock edge on the write side.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, all flags, both mask registers and `irq_req` are 0.
- R2: A 1 on an event input bit sets the flag at the same bit position in the next cycle and the flag stays set. Flag register A (address 0) uses bit 7 for ext pin 5, bit 6 for the 16-bit timer 2, bit 5 for ADC done, bit 3 for ext pin 3, bit 2 for timer 4, bit 1 for SPI and bit 0 for timer 3. Flag register B (address 1) uses bit 6 for UART receive error, bit 5 for UART receive full, bit 4 for UART transmit empty, bit 3 for time base, bit 2 for ext pin 1 and bit 0 for the TCC overflow.
- R3: A write to a flag register clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a flag.
- R4: When an event and a clearing write hit the same flag bit in the same cycle, the flag ends set.
- R5: A read of address 0 returns flag A AND mask A, and a read of address 1 returns flag B AND mask B. Unused addresses 5 to 7 read 0.
- R6: Mask A (address 2) and mask B (address 3) are plain 8-bit read/write registers.
- R7: Register A bit 4 and register B bits 7 and 1 are holes. They never become 1, whatever events or writes arrive.
- R8: While `uart_on` is 0, flag B bit 6 is cleared and stays 0, even when its event fires.
- R9: The ext pin 0 flag reads at address 4 bit 0, and the other bits of address 4 read 0. The `int0_evt` input sets the flag only while `int0_on` is 1. The flag is held at 0 while `int0_on` is 0. A write to address 4 with bit 0 equal to 0 clears it.
- R10: `irq_req` equals, one clock later, the OR of (flag A AND mask A), (flag B AND mask B) and the ext pin 0 flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_a | input | 8 | Event pulses for flag register A |
| evt_b | input | 8 | Event pulses for flag register B |
| int0_evt | input | 1 | Event pulse for the ext pin 0 flag |
| int0_on | input | 1 | Enable level for the ext pin 0 flag |
| uart_on | input | 1 | UART enable level |
| reg_addr | input | 3 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The hardest case is a flag that is set by an event, cleared by a write and masked, all in the same cycle, while an enable level is falling at that moment. Only then are set-over-clear priority, forced clearing and the registered request tested together. Random stimulus drives dense event pulses, frequent writes to every address and enable levels that toggle every few cycles, so these collisions occur often. Directed sequences then place each collision exactly: a collision of set and clear, an event while the UART is off, and an event while the ext pin 0 enable is off. Each sequence is followed by reads through the masks.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] ADDR_FLAG_A = 3'd0;
    localparam logic [AW-1:0] ADDR_FLAG_B = 3'd1;
    localparam logic [AW-1:0] ADDR_MASK_A = 3'd2;
    localparam logic [AW-1:0] ADDR_MASK_B = 3'd3;
    localparam logic [AW-1:0] ADDR_PIN0   = 3'd4;

    localparam logic [DW-1:0] HOLES_A = 8'b0001_0000;
    localparam logic [DW-1:0] HOLES_B = 8'b1000_0010;

    localparam int RXERR_BIT = 6;
endpackage

// File: rtl/ifr_flag_bank.sv
module ifr_flag_bank #(
    parameter int          W    = 8,
    parameter logic [W-1:0] HOLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_data,
    input  logic [W-1:0] hold_clr,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic nxt;
        always_comb begin
            if (HOLE[i] || hold_clr[i])
                nxt = 1'b0;
            else if (evt[i])
                nxt = 1'b1;
            else if (sw_wr && !sw_data[i])
                nxt = 1'b0;
            else
                nxt = flags[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else
                flags[i] <= nxt;
        end

        if (!HOLE[i]) begin : g_live
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (evt[i] && !hold_clr[i]) |=> flags[i]); // R4
            AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (!flags[i] && !evt[i]) |=> !flags[i]); // R3
            AST_FORCED_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                hold_clr[i] |=> !flags[i]); // R8
        end else begin : g_hole
            AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> !flags[i]); // R7
        end
    end
endmodule

// File: rtl/ifr_mask_reg.sv
module ifr_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr)
            q <= wdata;
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q == $past(wdata))); // R6
endmodule

// File: rtl/ifr_read_mux.sv
module ifr_read_mux
    import irq_flag_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] flag_a,
    input  logic [DW-1:0] flag_b,
    input  logic [DW-1:0] mask_a,
    input  logic [DW-1:0] mask_b,
    input  logic          pin0,
    output logic [DW-1:0] rdata
);
    always_comb begin
        unique case (addr)
            ADDR_FLAG_A: rdata = flag_a & mask_a;
            ADDR_FLAG_B: rdata = flag_b & mask_b;
            ADDR_MASK_A: rdata = mask_a;
            ADDR_MASK_B: rdata = mask_b;
            ADDR_PIN0:   rdata = {{(DW-1){1'b0}}, pin0};
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irq_flag_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt_a,
    input  logic [DW-1:0] evt_b,
    input  logic          int0_evt,
    input  logic          int0_on,
    input  logic          uart_on,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_req
);
    logic [DW-1:0] flag_a, flag_b, mask_a, mask_b;
    logic [DW-1:0] hold_b;
    logic [0:0]    pin0_flag;
    logic          pending;

    always_comb begin
        hold_b            = '0;
        hold_b[RXERR_BIT] = !uart_on;
    end

    ifr_flag_bank #(.W(DW), .HOLE(HOLES_A)) u_bank_a (
        .clk(clk), .rst_n(rst_n), .evt(evt_a),
        .sw_wr(reg_wr && reg_addr == ADDR_FLAG_A), .sw_data(reg_wdata),
        .hold_clr('0), .flags(flag_a));

    ifr_flag_bank #(.W(DW), .HOLE(HOLES_B)) u_bank_b (
        .clk(clk), .rst_n(rst_n), .evt(evt_b),
        .sw_wr(reg_wr && reg_addr == ADDR_FLAG_B), .sw_data(reg_wdata),
        .hold_clr(hold_b), .flags(flag_b));

    ifr_flag_bank #(.W(1), .HOLE(1'b0)) u_bank_pin0 (
        .clk(clk), .rst_n(rst_n), .evt(int0_evt),
        .sw_wr(reg_wr && reg_addr == ADDR_PIN0), .sw_data(reg_wdata[0]),
        .hold_clr(!int0_on), .flags(pin0_flag));

    ifr_mask_reg #(.W(DW)) u_mask_a (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr && reg_addr == ADDR_MASK_A),
        .wdata(reg_wdata), .q(mask_a));

    ifr_mask_reg #(.W(DW)) u_mask_b (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr && reg_addr == ADDR_MASK_B),
        .wdata(reg_wdata), .q(mask_b));

    ifr_read_mux u_rmux (
        .addr(reg_addr), .flag_a(flag_a), .flag_b(flag_b),
        .mask_a(mask_a), .mask_b(mask_b), .pin0(pin0_flag[0]),
        .rdata(reg_rdata));

    assign pending = (|(flag_a & mask_a)) | (|(flag_b & mask_b)) | pin0_flag[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_req <= 1'b0;
        else
            irq_req <= pending;
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq_req); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq_req); // R10
    AST_RXERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_on |=> !flag_b[RXERR_BIT]); // R8
    AST_PIN0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !int0_on |=> !pin0_flag[0]); // R9
endmodule

// File: tb/irq_flag_unit_tb.sv
module irq_flag_unit_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] evt_a = 0, evt_b = 0;
    logic       int0_evt = 0, int0_on = 0, uart_on = 0;
    logic [2:0] reg_addr = 0;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq_req;

    int checks = 0, errors = 0;
    logic [7:0] mf_a = 0, mf_b = 0, mm_a = 0, mm_b = 0;
    logic       mp0 = 0, mirq = 0;

    always #2 clk = ~clk;

    irq_flag_unit u_dut (.*);

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return mf_a & mm_a;
            3'd1: return mf_b & mm_b;
            3'd2: return mm_a;
            3'd3: return mm_b;
            3'd4: return {7'b0, mp0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] next_flags(input logic [7:0] f, input logic [7:0] e,
            input logic w, input logic [7:0] d, input logic [7:0] hole, input logic [7:0] hold);
        logic [7:0] r;
        r = w ? (f & d) : f;
        r = r | e;
        return r & ~hole & ~hold;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one cycle of inputs (at negedge), check reads and irq, then update model.
    task automatic step(input string req, input logic [7:0] ea, input logic [7:0] eb,
            input logic e0, input logic on0, input logic onu,
            input logic [2:0] a, input logic w, input logic [7:0] d);
        evt_a = ea; evt_b = eb; int0_evt = e0; int0_on = on0; uart_on = onu;
        reg_addr = a; reg_wr = w; reg_wdata = d;
        #1;
        check(req, reg_rdata, exp_read(a));
        check("R10", {7'b0, irq_req}, {7'b0, mirq});
        @(posedge clk);
        mirq = (|(mf_a & mm_a)) | (|(mf_b & mm_b)) | mp0;
        mf_a = next_flags(mf_a, ea, w && a == 3'd0, d, 8'h10, 8'h00);
        mf_b = next_flags(mf_b, eb, w && a == 3'd1, d, 8'h82, {1'b0, ~onu, 6'b0});
        mp0  = next_flags({7'b0, mp0}, {7'b0, e0}, w && a == 3'd4, d, 8'hFE, {7'b0, ~on0})[0];
        if (w && a == 3'd2) mm_a = d;
        if (w && a == 3'd3) mm_b = d;
        @(negedge clk);
    endtask

    task automatic rd(input string req, input logic [2:0] a);
        step(req, 0, 0, 0, int0_on, uart_on, a, 0, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            #1 reg_addr = a[2:0];
            #1 check("R1", reg_rdata, 8'h00);
        end
        check("R1", {7'b0, irq_req}, 8'h00);
        rst_n = 1;
        @(negedge clk);

        // R6: masks read/write
        step("R6", 0, 0, 0, 1, 1, 3'd2, 1, 8'hFF);
        step("R6", 0, 0, 0, 1, 1, 3'd3, 1, 8'hFF);
        rd("R6", 3'd2);
        rd("R6", 3'd3);
        // R2/R7: set all event bits including holes
        step("R2", 8'hFF, 8'hFF, 0, 1, 1, 3'd0, 0, 0);
        rd("R2", 3'd0);
        check("R7", reg_rdata, 8'hEF);
        rd("R7", 3'd1);
        check("R7", reg_rdata, 8'h7D);
        // R3: write 1s keeps, write pattern clears zeros only
        step("R3", 0, 0, 0, 1, 1, 3'd0, 1, 8'hFF);
        rd("R3", 3'd0);
        check("R3", reg_rdata, 8'hEF);
        step("R3", 0, 0, 0, 1, 1, 3'd0, 1, 8'h0F);
        rd("R3", 3'd0);
        check("R3", reg_rdata, 8'h0F);
        step("R3", 0, 0, 0, 1, 1, 3'd0, 1, 8'hF0);
        rd("R3", 3'd0);
        check("R3", reg_rdata, 8'h00);
        // R4: set and clear collide
        step("R4", 8'h01, 0, 0, 1, 1, 3'd0, 1, 8'h00);
        rd("R4", 3'd0);
        check("R4", reg_rdata, 8'h01);
        // R5: masked read
        step("R5", 0, 0, 0, 1, 1, 3'd2, 1, 8'h00);
        rd("R5", 3'd0);
        check("R5", reg_rdata, 8'h00);
        rd("R5", 3'd6);
        // R8: uart off clears rx error and blocks event
        step("R8", 0, 8'h40, 0, 1, 0, 3'd1, 0, 0);
        rd("R8", 3'd1);
        check("R8", reg_rdata & 8'h40, 8'h00);
        // R9: pin 0 flag
        step("R9", 0, 0, 1, 0, 1, 3'd4, 0, 0);
        rd("R9", 3'd4);
        check("R9", reg_rdata, 8'h00);
        step("R9", 0, 0, 1, 1, 1, 3'd4, 0, 0);
        rd("R9", 3'd4);
        check("R9", reg_rdata, 8'h01);
        step("R9", 0, 0, 0, 1, 1, 3'd4, 1, 8'hFE);
        rd("R9", 3'd4);
        check("R9", reg_rdata, 8'h00);

        // random phase (checks R5 reads and R10 irq each cycle)
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ea, eb, d;
            ea = $urandom() & $urandom();
            eb = $urandom() & $urandom();
            d  = $urandom();
            step("R5", (i % 4 == 0) ? ea : 8'h00, (i % 3 == 0) ? eb : 8'h00,
                 ($urandom() % 6) == 0, ($urandom() % 5) != 0, ($urandom() % 4) != 0,
                 3'($urandom() % 8), ($urandom() % 3) == 0, d);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule